// File: doc/BRIEF.md
# Multi-Function Pin Port

This block is a 22-pin digital I/O port. The pins are grouped behind three data registers of 8, 8 and 6 bits. Each pin is an LCD segment, an input or an output. Whether a pin is an LCD segment follows from a pin count that the LCD driver supplies. Whether a non-LCD pin is an input or an output comes from a per-pin direction register. Register reads and writes are resolved against that mode, so LCD pins read as zero and only output pins take written data.

Three alternate functions can take over pins when software enables them:

- a fault pulse on pin 7;
- a strobe on pin 6;
- a two-wire serial EEPROM clock on pin 4 with open-drain data on pin 5.

Each one takes effect only while the LCD pin count is under its own limit. The LCD driver and the EEPROM serial engine sit outside this block and connect through plain signals.

Top module: `pin_port_mux`

## Requirements
- R1: Register map by `regAddr`: 0, 1 and 2 are the data of pins 7..0, 15..8 and 21..16 (bit n is the lowest pin of the group plus n; unused upper bits read 0). 3, 4 and 5 are the direction bits of the same groups (1 = output), which read back as stored. 6 is the alternate control: bit0 fault enable, bit1 strobe enable, bit2 EEPROM enable. Address 7 reads 0. Reads are combinational; a write takes effect at the clock edge where `regWe` is high.
- R2: With `lcdCount` = N, pin i is an LCD pin when i >= 22 - N. An LCD pin reads as 0 and never has `padOe` set, except pins 4 and 5 while the EEPROM function is active.
- R3: A data write updates only pins that are outputs and not LCD. Input and LCD pins keep the value they held.
- R4: A data read returns the `padIn` level for every non-LCD pin, input or output.
- R5: A non-LCD pin with direction 1 has `padOe` = 1 and drives its stored data on `padOut`. Otherwise `padOe` = 0.
- R6: When the fault enable is 1, pin 7's direction is 1 and `lcdCount` < 15, `padOut[7]` follows `faultPulse`.
- R7: When the strobe enable is 1, pin 6's direction is 1 and `lcdCount` < 16, `padOut[6]` follows `strobeIn`.
- R8: When the EEPROM enable is 1 and `lcdCount` < 18, pin 4 has `padOe` = 1 and `padOut` = `eeClk`, whatever its direction. Pin 5 has `padOut` = 0 and `padOe` = NOT `eeSdaOut`. `eeSdaIn` always equals `padIn[5]`.
- R9: An enabled alternate function whose `lcdCount` limit is not met has no effect, and its pins behave as in R2, R3 and R5.
- R10: After reset all data and direction bits are 0, so no pin is driven, and the alternate control reads 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| lcdCount | input | 5 | Number of pins, counted from pin 21 downward, used as LCD segments |
| padIn | input | 22 | Pin levels seen at the pads |
| padOut | output | 22 | Value driven on each pad |
| padOe | output | 22 | Output enable of each pad |
| faultPulse | input | 1 | Fault pulse source for pin 7 |
| strobeIn | input | 1 | Strobe source for pin 6 |
| eeClk | input | 1 | EEPROM serial clock from the serial engine |
| eeSdaOut | input | 1 | EEPROM data from the engine; 0 pulls pin 5 low |
| eeSdaIn | output | 1 | Level of pin 5 returned to the engine |

## Verification
The assertions take for granted that at most one register write happens per cycle. They also take for granted that `lcdCount` and the alternate sources are steady around a data write, so a change on a non-driven pin can only come from that write. The bench issues every write alone in its own cycle. It changes `lcdCount`, `faultPulse`, `strobeIn` and the EEPROM signals only between register accesses. Its pad model gives every pin that is not driven a fixed level, and gives every driven pin its `padOut` value.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int NUM_GROUPS = 3;

  typedef enum logic [1:0] {
    RD_DATA = 2'd0,
    RD_DIR  = 2'd1,
    RD_ALT  = 2'd2,
    RD_NONE = 2'd3
  } rdKind_t;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] wrData;
    logic [NUM_GROUPS-1:0] wrDir;
    logic                  wrAlt;
    rdKind_t               rdKind;
    logic [1:0]            rdGroup;
  } portStrobe_t;
endpackage

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pin_port_pkg::*;
(
  input  logic [2:0]  regAddr,
  input  logic        regWe,
  output portStrobe_t strobe
);
  logic [2:0] dirIdx;
  assign dirIdx = regAddr - 3'd3;

  always_comb begin
    strobe = '0;
    strobe.rdKind = RD_NONE;
    unique case (regAddr)
      3'd0, 3'd1, 3'd2: begin
        strobe.rdKind = RD_DATA;
        strobe.rdGroup = regAddr[1:0];
        strobe.wrData[regAddr[1:0]] = regWe;
      end
      3'd3, 3'd4, 3'd5: begin
        strobe.rdKind = RD_DIR;
        strobe.rdGroup = dirIdx[1:0];
        strobe.wrDir[dirIdx[1:0]] = regWe;
      end
      3'd6: begin
        strobe.rdKind = RD_ALT;
        strobe.wrAlt = regWe;
      end
      default: strobe.rdKind = RD_NONE;
    endcase
  end
endmodule

// File: rtl/pin_port_datapath.sv
module pin_port_datapath
  import pin_port_pkg::*;
#(
  parameter int G0_W = 8,
  parameter int G1_W = 8,
  parameter int G2_W = 6,
  parameter int CNT_W = 5,
  parameter int FAULT_PIN = 7,
  parameter int FAULT_LIMIT = 15,
  parameter int STROBE_PIN = 6,
  parameter int STROBE_LIMIT = 16,
  parameter int SCL_PIN = 4,
  parameter int SDA_PIN = 5,
  parameter int EE_LIMIT = 18,
  localparam int NUM_PINS = G0_W + G1_W + G2_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         strobe,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic [CNT_W-1:0]    lcdCount,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic                faultPulse,
  input  logic                strobeIn,
  input  logic                eeClk,
  input  logic                eeSdaOut,
  output logic                eeSdaIn,
  output logic [NUM_PINS-1:0] dirBits,
  output logic [NUM_PINS-1:0] dataBits,
  output logic [2:0]          altBits
);
  localparam int OFF1 = G0_W;
  localparam int OFF2 = G0_W + G1_W;

  function automatic int groupOf(int pin);
    if (pin < OFF1) return 0;
    if (pin < OFF2) return 1;
    return 2;
  endfunction

  function automatic int bitOf(int pin);
    if (pin < OFF1) return pin;
    if (pin < OFF2) return pin - OFF1;
    return pin - OFF2;
  endfunction

  logic [NUM_PINS-1:0] dataReg, dirReg, lcdMask, outMode;
  logic [2:0] altReg;
  logic faultOn, strobeOn, eeOn;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      lcdMask[i] = (int'(lcdCount) + i >= NUM_PINS);
    end
  end

  assign outMode = dirReg & ~lcdMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      altReg  <= 3'b011;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strobe.wrData[groupOf(i)] && outMode[i]) dataReg[i] <= regWdata[bitOf(i)];
        if (strobe.wrDir[groupOf(i)]) dirReg[i] <= regWdata[bitOf(i)];
      end
      if (strobe.wrAlt) altReg <= regWdata[2:0];
    end
  end

  always_comb begin
    regRdata = '0;
    case (strobe.rdKind)
      RD_DATA: begin
        for (int i = 0; i < NUM_PINS; i++) begin
          if (groupOf(i) == int'(strobe.rdGroup)) regRdata[bitOf(i)] = padIn[i] & ~lcdMask[i];
        end
      end
      RD_DIR: begin
        for (int i = 0; i < NUM_PINS; i++) begin
          if (groupOf(i) == int'(strobe.rdGroup)) regRdata[bitOf(i)] = dirReg[i];
        end
      end
      RD_ALT:  regRdata = {5'd0, altReg};
      default: regRdata = '0;
    endcase
  end

  assign faultOn  = altReg[0] && dirReg[FAULT_PIN] && (int'(lcdCount) < FAULT_LIMIT);
  assign strobeOn = altReg[1] && dirReg[STROBE_PIN] && (int'(lcdCount) < STROBE_LIMIT);
  assign eeOn     = altReg[2] && (int'(lcdCount) < EE_LIMIT);

  always_comb begin
    padOe  = outMode;
    padOut = dataReg;
    if (faultOn)  padOut[FAULT_PIN]  = faultPulse;
    if (strobeOn) padOut[STROBE_PIN] = strobeIn;
    if (eeOn) begin
      padOe[SCL_PIN]  = 1'b1;
      padOut[SCL_PIN] = eeClk;
      padOe[SDA_PIN]  = ~eeSdaOut;
      padOut[SDA_PIN] = 1'b0;
    end
  end

  assign eeSdaIn  = padIn[SDA_PIN];
  assign dirBits  = dirReg;
  assign dataBits = dataReg;
  assign altBits  = altReg;
endmodule

// File: rtl/pin_port_mux.sv
module pin_port_mux
  import pin_port_pkg::*;
#(
  parameter int G0_W = 8,
  parameter int G1_W = 8,
  parameter int G2_W = 6,
  parameter int CNT_W = 5,
  localparam int NUM_PINS = G0_W + G1_W + G2_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regAddr,
  input  logic                regWe,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic [CNT_W-1:0]    lcdCount,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic                faultPulse,
  input  logic                strobeIn,
  input  logic                eeClk,
  input  logic                eeSdaOut,
  output logic                eeSdaIn
);
  portStrobe_t strobe;
  logic [NUM_PINS-1:0] dirBits, dataBits;
  logic [2:0] altBits;

  pin_port_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWe(regWe),
    .strobe(strobe)
  );

  pin_port_datapath #(
    .G0_W(G0_W), .G1_W(G1_W), .G2_W(G2_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWdata(regWdata), .regRdata(regRdata),
    .lcdCount(lcdCount), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .faultPulse(faultPulse), .strobeIn(strobeIn),
    .eeClk(eeClk), .eeSdaOut(eeSdaOut), .eeSdaIn(eeSdaIn),
    .dirBits(dirBits), .dataBits(dataBits), .altBits(altBits)
  );
endmodule

// File: rtl/pin_port_checker.sv
module pin_port_checker #(
  parameter int NUM_PINS = 22,
  parameter int G0_W = 8,
  parameter int CNT_W = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          regAddr,
  input logic                regWe,
  input logic [CNT_W-1:0]    lcdCount,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                faultPulse,
  input logic                strobeIn,
  input logic [NUM_PINS-1:0] dirBits,
  input logic [NUM_PINS-1:0] dataBits,
  input logic [2:0]          altBits
);
  localparam logic [NUM_PINS-1:0] EE_PINS = NUM_PINS'(6'b110000);
  localparam logic [NUM_PINS-1:0] G0_PLAIN = NUM_PINS'((1 << G0_W) - 1) & ~NUM_PINS'(8'hF0);

  logic [NUM_PINS-1:0] lcdChk;
  logic eeChk, faultChk, strobeChk;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) lcdChk[i] = (int'(lcdCount) > NUM_PINS - 1 - i);
  end
  assign eeChk     = altBits[2] && (lcdCount <= CNT_W'(17));
  assign faultChk  = altBits[0] && dirBits[7] && (lcdCount <= CNT_W'(14));
  assign strobeChk = altBits[1] && dirBits[6] && (lcdCount <= CNT_W'(15));

  // R2: LCD pins stay undriven apart from the serial pins in EEPROM mode
  assert_lcd_undriven_R2: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & lcdChk & ~(eeChk ? EE_PINS : '0)) == '0);

  // R3: a data write to group 0 leaves every undriven plain pin unchanged
  assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd0) |=>
      ((padOut ^ $past(padOut)) & ~$past(padOe) & G0_PLAIN) == '0);

  // R6 and R9: the fault pin follows the pulse only inside its limit
  assert_fault_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    padOut[7] == (faultChk ? faultPulse : dataBits[7]));

  // R7 and R9: the strobe pin follows the strobe only inside its limit
  assert_strobe_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    padOut[6] == (strobeChk ? strobeIn : dataBits[6]));

  // R8: the serial data pin never drives high and the clock pin is enabled
  assert_sda_open_drain_R8: assert property (@(posedge clk) disable iff (!rstN)
    eeChk |-> (!(padOe[5] && padOut[5]) && padOe[4]));
endmodule

bind pin_port_mux pin_port_checker #(
  .NUM_PINS(NUM_PINS), .G0_W(G0_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .lcdCount(lcdCount), .padOut(padOut), .padOe(padOe),
  .faultPulse(faultPulse), .strobeIn(strobeIn),
  .dirBits(dirBits), .dataBits(dataBits), .altBits(altBits)
);

// File: tb/test_pin_port_mux.sv
module test_pin_port_mux;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] EXT_LEVEL = 22'h2AAAAA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [4:0] lcdCount = '0;
  logic [21:0] padIn, padOut, padOe;
  logic faultPulse = 1'b0, strobeIn = 1'b0, eeClk = 1'b0, eeSdaOut = 1'b1;
  logic eeSdaIn;
  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign padIn = (padOe & padOut) | (~padOe & EXT_LEVEL);

  pin_port_mux i_pin_port_mux (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .lcdCount(lcdCount),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .faultPulse(faultPulse), .strobeIn(strobeIn),
    .eeClk(eeClk), .eeSdaOut(eeSdaOut), .eeSdaIn(eeSdaIn)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    #1;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R10 padOe after reset", 32'(padOe), 32'h0);
    chk("R10 padOut after reset", 32'(padOut), 32'h0);
    regRead(3'd6, v); chk("R10 alt control reset", 32'(v), 32'h03);
    regRead(3'd3, v); chk("R10 dir group0 reset", 32'(v), 32'h00);
    regRead(3'd0, v); chk("R4 read group0 inputs", 32'(v), 32'hAA);
    regRead(3'd2, v); chk("R1 read group2 inputs", 32'(v), 32'h2A);
    regRead(3'd7, v); chk("R1 unused address", 32'(v), 32'h00);
  endtask

  task automatic t_output();
    logic [7:0] v;
    lcdCount = 5'd0;
    regWrite(3'd6, 8'h00);
    regRead(3'd6, v); chk("R1 alt control readback", 32'(v), 32'h00);
    regWrite(3'd3, 8'hFF);
    regWrite(3'd0, 8'hA5);
    chk("R5 group0 drive value", 32'(padOut[7:0]), 32'hA5);
    chk("R5 group0 enables", 32'(padOe[7:0]), 32'hFF);
    regRead(3'd0, v); chk("R4 read driven pins", 32'(v), 32'hA5);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    regWrite(3'd4, 8'h0F);
    regWrite(3'd1, 8'hFF);
    regRead(3'd1, v); chk("R4 mixed group1 read", 32'(v), 32'hAF);
    regWrite(3'd4, 8'hFF);
    chk("R3 input pins kept value", 32'(padOut[15:8]), 32'h0F);
    regRead(3'd4, v); chk("R1 dir group1 readback", 32'(v), 32'hFF);
  endtask

  task automatic t_lcd();
    logic [7:0] v;
    lcdCount = 5'd4;
    regWrite(3'd5, 8'h3F);
    regWrite(3'd2, 8'h3F);
    chk("R2 LCD pins undriven", 32'(padOe[21:16]), 32'h03);
    regRead(3'd2, v); chk("R2 LCD pins read zero", 32'(v), 32'h03);
    regRead(3'd5, v); chk("R1 dir group2 readback", 32'(v), 32'h3F);
    lcdCount = 5'd0;
    settle();
    chk("R3 LCD pins kept value", 32'(padOut[21:16]), 32'h03);
    chk("R5 group2 all enabled", 32'(padOe[21:16]), 32'h3F);
  endtask

  task automatic t_fault();
    lcdCount = 5'd0;
    faultPulse = 1'b0;
    regWrite(3'd6, 8'h01);
    chk("R6 fault pulse low on pin 7", 32'(padOut[7]), 32'h0);
    faultPulse = 1'b1; settle();
    chk("R6 fault pulse high on pin 7", 32'(padOut[7]), 32'h1);
    faultPulse = 1'b0;
    regWrite(3'd3, 8'h7F);
    chk("R6 pin 7 input ignores fault", 32'(padOut[7]), 32'h1);
    regWrite(3'd3, 8'hFF);
    lcdCount = 5'd15; settle();
    chk("R9 fault over limit value", 32'(padOut[7]), 32'h1);
    chk("R9 fault over limit enable", 32'(padOe[7]), 32'h0);
    lcdCount = 5'd14; settle();
    chk("R6 fault at limit minus one", 32'(padOut[7]), 32'h0);
  endtask

  task automatic t_strobe();
    lcdCount = 5'd0;
    strobeIn = 1'b1;
    regWrite(3'd6, 8'h02);
    chk("R7 strobe on pin 6", 32'(padOut[6]), 32'h1);
    lcdCount = 5'd16; settle();
    chk("R9 strobe over limit", 32'(padOut[6]), 32'h0);
    lcdCount = 5'd15; settle();
    chk("R7 strobe at limit minus one", 32'(padOut[6]), 32'h1);
    strobeIn = 1'b0; settle();
    chk("R7 strobe follows low", 32'(padOut[6]), 32'h0);
  endtask

  task automatic t_eeprom();
    lcdCount = 5'd17;
    eeClk = 1'b1; eeSdaOut = 1'b0;
    regWrite(3'd3, 8'h00);
    regWrite(3'd6, 8'h04);
    chk("R8 serial pins enables", 32'(padOe[5:4]), 32'h3);
    chk("R8 serial pins values", 32'(padOut[5:4]), 32'h1);
    chk("R8 data pin pulled low", 32'(eeSdaIn), 32'h0);
    eeSdaOut = 1'b1; eeClk = 1'b0; settle();
    chk("R8 data pin released", 32'(padOe[5]), 32'h0);
    chk("R8 data pin level returned", 32'(eeSdaIn), 32'h1);
    chk("R8 clock follows engine", 32'(padOut[4]), 32'h0);
    lcdCount = 5'd18; settle();
    chk("R9 EEPROM over limit", 32'(padOe[5:4]), 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_output();
    t_ignore();
    t_lcd();
    t_fault();
    t_strobe();
    t_eeprom();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule